// File: doc/BRIEF.md
# Built-in Test Image Sequencer

This block supplies the pixel stream for a display's built-in test images. When the test request level is high (both luminance-select pins high, which is also their state when the pins are left unconnected), the block replaces stored video with a series of four generated images: a grid of diagonal lines framed by a one-pixel border, then a solid red field, a solid green field and a solid yellow field. Each image is held for a fixed number of scan frames. The scan rate is generated outside the block.

The scan logic tells the block when each scan frame begins and which row and column it is fetching. The block returns a 4-bit pixel code one clock later, in the same encoding that normal video uses. The four-image list is played a set number of times. After that the output stays on solid yellow for as long as the request is held. When the request is removed and later raised again, the sequence starts over from the first image with a full pass budget.

Top module: `selftest_seq`

## Requirements
- R1: While `test_req` is low, `pix_code` is 4'b0000 (one cycle after the low level is sampled). The sequence is held at its start and does not advance, and `frame_start` pulses that arrive while the request is low are not counted.
- R2: In the first image, a pixel is yellow (4'b1111) when it lies on row 0, row ROWS-1, column 0 or column COLS-1, or when (row + col) modulo DIAG_PERIOD is 0. Every other pixel is black (4'b0000).
- R3: The pixel code is {red MSB, red LSB, green MSB, green LSB}. Solid red is 4'b1100 at every pixel, solid green is 4'b0011 and solid yellow is 4'b1111. No other code is ever produced.
- R4: The images run in the order lines-and-border, red, green, yellow. Each image advances after exactly DWELL_FRAMES `frame_start` pulses have been counted with the request high.
- R5: After the four-image list has completed PASSES times, the output stays on solid yellow, whatever further `frame_start` pulses arrive, for as long as `test_req` stays high.
- R6: When `test_req` drops and rises again, the sequence restarts at the first image with a fresh dwell count and a fresh pass count.
- R7: `pix_code` is registered. It reflects the `row`, `col` and sequence state of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_req | input | 1 | Test-mode level (both luminance selects high) |
| frame_start | input | 1 | One-cycle pulse at the start of each scan frame |
| row | input | $clog2(ROWS) | Row of the pixel being scanned |
| col | input | $clog2(COLS) | Column of the pixel being scanned |
| pix_code | output | 4 | Generated pixel code, registered |

## Verification
The bench builds the block with DWELL_FRAMES reduced to 4 and keeps PASSES at 3. With those values the whole run is reachable in a few hundred cycles: all three passes, the switch into the locked yellow image, and a restart after the request drops. ROWS and COLS keep their default 240 by 320, so the bench probes the border on the true last row and last column and on lines where the diagonal sum wraps. The dwell boundary is checked from both sides: once one frame before an image should change, and once at the frame where it does change.

// File: rtl/selftest_pkg.sv
// Shared types for the test image sequencer: image identifiers and
// pixel codes. Code bit order is {red MSB, red LSB, green MSB, green LSB}.
package selftest_pkg;

    typedef enum logic [1:0] {
        PAT_LINES  = 2'd0,
        PAT_RED    = 2'd1,
        PAT_GREEN  = 2'd2,
        PAT_YELLOW = 2'd3
    } pat_e;

    localparam pat_e PAT_FIRST = PAT_LINES;
    localparam pat_e PAT_LAST  = PAT_YELLOW;

    localparam logic [3:0] CODE_BLACK  = 4'b0000;
    localparam logic [3:0] CODE_RED    = 4'b1100;
    localparam logic [3:0] CODE_GREEN  = 4'b0011;
    localparam logic [3:0] CODE_YELLOW = 4'b1111;

endpackage

// File: rtl/st_dwell_timer.sv
// Counts scan frames while the test request is high and pulses `step`
// on the frame that completes one dwell period.
// Assumes frame_start is a single-cycle pulse. The count clears whenever
// the request is low, so pulses that arrive while idle are discarded.
module st_dwell_timer #(
    parameter int DWELL_FRAMES = 1300,
    localparam int CNT_W = $clog2(DWELL_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_req,
    input  logic frame_start,
    output logic step
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DWELL_FRAMES - 1);

    logic [CNT_W-1:0] frame_cnt;

    // Step when the last frame of the dwell period arrives in test mode.
    always_comb step = test_req && frame_start && (frame_cnt == LAST_CNT);

    // Frame counter: cleared when idle, wraps at the end of each dwell.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_req) begin
            frame_cnt <= '0;
        end else if (frame_start) begin
            frame_cnt <= step ? '0 : frame_cnt + 1'b1;
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= LAST_CNT);

    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_req |=> frame_cnt == '0);

endmodule

// File: rtl/st_pattern_fsm.sv
// Holds the current test image and the pass count. On each dwell step the
// image advances through the fixed list. At the end of the last pass the
// machine locks on the final (yellow) image. Dropping the request clears
// every piece of state, so a new request begins at the first image.
module st_pattern_fsm
    import selftest_pkg::*;
#(
    parameter int PASSES = 3,
    localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_req,
    input  logic frame_start,
    input  logic step,
    output pat_e pat_idx
);

    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    logic [PASS_W-1:0] pass_cnt;
    logic              locked;

    // Image, pass and lock state update.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_req) begin
            pat_idx  <= PAT_FIRST;
            pass_cnt <= '0;
            locked   <= 1'b0;
        end else if (step && !locked) begin
            if (pat_idx == PAT_LAST) begin
                if (pass_cnt == LAST_PASS) begin
                    locked <= 1'b1;
                end else begin
                    pass_cnt <= pass_cnt + 1'b1;
                    pat_idx  <= PAT_FIRST;
                end
            end else begin
                pat_idx <= pat_e'(pat_idx + 2'd1);
            end
        end
    end

    assert_no_step_without_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !frame_start) |=> $stable(pat_idx));

    assert_lock_holds_yellow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && test_req) |=> (locked && pat_idx == PAT_LAST));

    assert_restart_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_req |=> (pat_idx == PAT_FIRST && pass_cnt == '0 && !locked));

endmodule

// File: rtl/st_pixel_render.sv
// Produces the registered pixel code for the current image at the scanned
// row and column. Outputs black while the test request is low.
// Assumes row < ROWS and col < COLS.
module st_pixel_render
    import selftest_pkg::*;
#(
    parameter int ROWS        = 240,
    parameter int COLS        = 320,
    parameter int DIAG_PERIOD = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int SUM_W = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_req,
    input  pat_e             pat_idx,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [3:0]       pix_code
);

    logic [SUM_W-1:0] diag_sum;
    logic             on_border;
    logic             on_diag;
    logic [3:0]       next_code;

    // Border and diagonal membership of the scanned pixel.
    always_comb begin
        diag_sum  = SUM_W'(row) + SUM_W'(col);
        on_diag   = (diag_sum % SUM_W'(DIAG_PERIOD)) == '0;
        on_border = (row == '0) || (row == ROW_W'(ROWS - 1)) ||
                    (col == '0) || (col == COL_W'(COLS - 1));
    end

    // Code selection for the active image.
    always_comb begin
        unique case (pat_idx)
            PAT_LINES:  next_code = (on_border || on_diag) ? CODE_YELLOW : CODE_BLACK;
            PAT_RED:    next_code = CODE_RED;
            PAT_GREEN:  next_code = CODE_GREEN;
            default:    next_code = CODE_YELLOW;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_req) pix_code <= CODE_BLACK;
        else                     pix_code <= next_code;
    end

    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_code == CODE_BLACK || pix_code == CODE_RED ||
         pix_code == CODE_GREEN || pix_code == CODE_YELLOW));

    assert_idle_black_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_req |=> pix_code == CODE_BLACK);

    assert_solid_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && pat_idx == PAT_RED) |=> pix_code == CODE_RED);

endmodule

// File: rtl/selftest_seq.sv
// Top of the test image sequencer. The dwell timer counts scan frames, the
// pattern machine picks the image and the pass, and the renderer turns the
// image and the scan position into a registered 4-bit pixel code.
// Assumes frame_start comes from the scan logic running at full rate.
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int ROWS         = 240,
    parameter int COLS         = 320,
    parameter int DIAG_PERIOD  = 8,
    parameter int DWELL_FRAMES = 1300,
    parameter int PASSES       = 3,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_req,
    input  logic             frame_start,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [3:0]       pix_code
);

    logic step;
    pat_e pat_idx;

    st_dwell_timer #(
        .DWELL_FRAMES(DWELL_FRAMES)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_req   (test_req),
        .frame_start(frame_start),
        .step       (step)
    );

    st_pattern_fsm #(
        .PASSES(PASSES)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_req   (test_req),
        .frame_start(frame_start),
        .step       (step),
        .pat_idx    (pat_idx)
    );

    st_pixel_render #(
        .ROWS       (ROWS),
        .COLS       (COLS),
        .DIAG_PERIOD(DIAG_PERIOD)
    ) i_render (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_req(test_req),
        .pat_idx (pat_idx),
        .row     (row),
        .col     (col),
        .pix_code(pix_code)
    );

endmodule

// File: tb/test_selftest_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: probe tasks drive a pixel position and queue the
// expected code; a monitor pops and compares one cycle later.
module test_selftest_seq;

    localparam int ROWS   = 240;
    localparam int COLS   = 320;
    localparam int DIAG   = 8;
    localparam int DWELL  = 4;
    localparam int PASSES = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_req = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] row = '0;
    logic [8:0] col = '0;
    logic [3:0] pix_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    selftest_seq #(
        .ROWS(ROWS), .COLS(COLS), .DIAG_PERIOD(DIAG),
        .DWELL_FRAMES(DWELL), .PASSES(PASSES)
    ) i_selftest_seq (
        .clk(clk), .rst_n(rst_n), .test_req(test_req),
        .frame_start(frame_start), .row(row), .col(col), .pix_code(pix_code)
    );

    // Expected code from the requirements; p = -1 means idle (black).
    function automatic logic [3:0] model(int p, int r, int c);
        case (p)
            0: return (r == 0 || r == ROWS-1 || c == 0 || c == COLS-1 ||
                       ((r + c) % DIAG) == 0) ? 4'b1111 : 4'b0000;
            1: return 4'b1100;
            2: return 4'b0011;
            3: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    // Monitor: compare the output with the oldest queued expectation.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (pix_code !== it.exp) begin
                errors++;
                $display("FAIL %s: pix_code=%b expected=%b", it.tag, pix_code, it.exp);
            end
        end
    end

    task automatic probe(int p, int r, int c, string tag);
        @(negedge clk);
        #1;
        row = 8'(r);
        col = 9'(c);
        sb_q.push_back('{exp: model(p, r, c), tag: tag});
    endtask

    task automatic check_image(int p, string tag);
        probe(p, 0, 5, tag);
        probe(p, 1, 1, tag);
        probe(p, 1, 7, tag);
        probe(p, 2, 3, tag);
        probe(p, ROWS-1, 100, tag);
        probe(p, 100, COLS-1, tag);
        probe(p, 10, 14, tag);
        probe(p, 57, 0, tag);
    endtask

    task automatic frames(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1 frame_start = 1'b1;
            @(negedge clk); #1 frame_start = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pix_code !== 4'b0000) begin
            errors++;
            $display("FAIL R1 reset: pix_code=%b expected=0000", pix_code);
        end

        // R1: idle output black and idle frames not counted.
        frames(3);
        check_image(-1, "R1 idle");
        drain();

        // R2/R7: first image, probed on consecutive cycles.
        #1 test_req = 1'b1;
        check_image(0, "R2 R7 lines image");
        drain();

        // R4/R3/R5: full sequence with the dwell checked on both sides.
        for (int pass = 0; pass < PASSES; pass++) begin
            for (int p = 0; p < 4; p++) begin
                check_image(p, "R3 R4 image");
                drain();
                frames(DWELL - 1);
                check_image(p, "R4 dwell not yet over");
                drain();
                frames(1);
            end
        end
        check_image(3, "R5 locked yellow");
        drain();
        frames(3 * DWELL);
        check_image(3, "R5 stays yellow");
        drain();

        // R1/R6: drop the request, pulse frames while idle, then re-request.
        @(negedge clk); #1 test_req = 1'b0;
        drain();
        check_image(-1, "R1 dropped");
        frames(2);
        drain();
        @(negedge clk); #1 test_req = 1'b1;
        check_image(0, "R6 restart first image");
        drain();
        frames(DWELL - 1);
        check_image(0, "R6 fresh dwell count");
        drain();
        frames(1);
        check_image(1, "R6 advance to red");
        drain();
        frames(3 * DWELL);
        check_image(0, "R6 fresh pass count");
        drain();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule